// File: doc/BRIEF.md
# Programmable Chip-Select Bank Decoder

This block sits between a 32-bit CPU-side address path and an external parallel bus that has eight chip-select lines. Each address presented with a valid strobe is compared with eight programmable bank windows. One cycle later the block drives at most one chip-select, the address relative to the bank that was hit, and a decode-error flag when no window matched. Each window is defined by a single configuration word. Bit 0 of that word enables the bank. Bits [31:17] give the bank base, so banks sit on 128 KiB boundaries. Bits [15:1] form a compare mask in which field bit k selects address bit k+16 for comparison.

Software programs the windows through a small word-addressed register port. The base word of slot n sits at byte offset 0x100 + 0x10·n. Each slot also has five timing words: four at 0x200 + 0x10·n + {0x0, 0x4, 0x8, 0xC} and one at 0x300 + 0x10·n. The timing words are only stored and read back here. A strap input, sampled during reset, exchanges the chip-select lines of slots 0 and 1. The strap value shows up as a cleared enable bit in slot 0 after reset. Slots 0 and 1 also keep a legacy behaviour: if the whole configuration word of either slot is zero, that slot hits every address, whatever its enable bit says.

Top module: `csb_decoder`

## Requirements
- R1: After reset, the slot-0 base word reads 0x00000001 when `boot_swap` was low during reset and 0x00000000 when it was high. All other base words read 0.
- R2: When `cpu_valid` is high, the decode result appears on `out_valid`, `cs`, `bank_off` and `dec_err` on the following clock edge. When `cpu_valid` is low, the next cycle shows `out_valid`, `cs` and `dec_err` all low.
- R3: An enabled slot hits when every address bit in [31:17] whose mask bit (field bit k for address bit k+16) is 1 equals the base bit. Unmasked bits and bits [16:0] never affect the match.
- R4: If several slots hit, the lowest-numbered slot wins, and `cs` never has more than one bit set.
- R5: `bank_off` equals the CPU address with those bits of [31:17] cleared whose mask bit is set in the winning slot.
- R6: If no slot hits, `cs` is 0, `dec_err` is 1 and `bank_off` is 0.
- R7: A slot 0 or slot 1 whose base word is entirely zero hits every address even though its enable bit is clear. Writing 0xFFFFFFFF parks such a slot so that it hits only addresses whose bits [31:17] are all ones.
- R8: Slots 2 to 7 never hit while their enable bit (bit 0) is clear, even when the word is zero.
- R9: With the strap latched high, slot 0 drives `cs[1]` and slot 1 drives `cs[0]`. Priority still follows slot number.
- R10: Each of the 40 timing words stores the written 32-bit value and returns it on read. Timing words have no effect on decoding.
- R11: A read returns data on `cfg_rdata` one cycle after `cfg_addr` is presented. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_swap | input | 1 | Strap sampled while reset is high; exchanges slots 0 and 1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the offset presented one cycle earlier |
| cpu_valid | input | 1 | CPU address valid |
| cpu_addr | input | 32 | CPU-side address |
| out_valid | output | 1 | Decode result valid |
| cs | output | 8 | Active-high chip selects, at most one set |
| bank_off | output | 32 | Bank-relative address |
| dec_err | output | 1 | No slot matched |

## Verification
Directed addresses against hand-built windows of 32 MiB and 16 MiB confirm the base/mask compare and the offset clearing. Addresses just outside a window confirm that a miss raises the error flag. Overlapping windows separate correct priority from wrong priority. Zero-word and all-ones words in slots 0 and 1 separate the legacy catch-all from an ordinary disabled slot. A second reset with the strap high shows whether the swap acts on the chip-select lines rather than on the priority order. Random windows with sparse masks, hit by addresses drawn near a chosen base with random flips, exercise the don't-care bits and multiple hits under a bench model.

// File: rtl/csb_pkg.sv
`timescale 1ns/1ps
package csb_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int CFG_AW   = 12;
  localparam int GRAN_LSB = 17;               // 128 KiB bank granularity
  localparam int CMP_W    = ADDR_W - GRAN_LSB; // compared address bits
  localparam logic [3:0] PG_BASE  = 4'h1;     // base words page
  localparam logic [3:0] PG_TIM_A = 4'h2;     // timing words 0..3
  localparam logic [3:0] PG_TIM_B = 4'h3;     // timing word 4

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_BASE = 2'd1,
    RS_TIM  = 2'd2
  } rsel_e;
endpackage

// File: rtl/csb_regfile.sv
`timescale 1ns/1ps
module csb_regfile #(
  parameter int NUM_BANKS = 8,
  parameter int TIM_WORDS = 5
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    boot_swap,
  input  logic                                    cfg_we,
  input  logic [csb_pkg::CFG_AW-1:0]              cfg_addr,
  input  logic [csb_pkg::DATA_W-1:0]              cfg_wdata,
  output logic [csb_pkg::DATA_W-1:0]              cfg_rdata,
  output logic [NUM_BANKS-1:0][csb_pkg::DATA_W-1:0] bases,
  output logic                                    swap_o
);
  import csb_pkg::*;

  localparam int BW     = $clog2(NUM_BANKS);
  localparam int TDEPTH = NUM_BANKS * TIM_WORDS;
  localparam int TIW    = $clog2(TDEPTH);

  logic [3:0]    page, slot_f, wsel;
  logic [BW-1:0] slot;
  logic          slot_ok, is_base, is_tim;
  logic [2:0]    tim_word;
  logic [TIW-1:0] tidx;

  assign page   = cfg_addr[11:8];
  assign slot_f = cfg_addr[7:4];
  assign wsel   = cfg_addr[3:0];
  assign slot   = slot_f[BW-1:0];
  assign slot_ok = (int'(slot_f) < NUM_BANKS);
  assign is_base = slot_ok && (page == PG_BASE) && (wsel == 4'h0);
  assign is_tim  = slot_ok && (((page == PG_TIM_A) && (wsel[1:0] == 2'b00)) ||
                               ((page == PG_TIM_B) && (wsel == 4'h0)));
  assign tim_word = (page == PG_TIM_A) ? {1'b0, wsel[3:2]} : 3'd4;
  assign tidx = TIW'(int'(slot) * TIM_WORDS + int'(tim_word));

  // Base words: flops, all compared in parallel by the matcher.
  logic [NUM_BANKS-1:0][DATA_W-1:0] base_q;
  logic swap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BANKS; i++) base_q[i] <= '0;
      base_q[0] <= {{(DATA_W-1){1'b0}}, ~boot_swap};
      swap_q    <= boot_swap;
    end else if (cfg_we && is_base) begin
      base_q[slot] <= cfg_wdata;
    end
  end

  assign bases  = base_q;
  assign swap_o = swap_q;

  // Timing words: storage only, single-port RAM style.
  logic [DATA_W-1:0] tim_mem [TDEPTH];
  logic [DATA_W-1:0] tim_rd_q, base_rd_q;
  rsel_e             rs_q;

  always_ff @(posedge clk) begin
    if (cfg_we && is_tim) tim_mem[tidx] <= cfg_wdata;
    tim_rd_q <= tim_mem[tidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q      <= RS_NONE;
      base_rd_q <= '0;
    end else begin
      base_rd_q <= base_q[slot];
      if (is_base)     rs_q <= RS_BASE;
      else if (is_tim) rs_q <= RS_TIM;
      else             rs_q <= RS_NONE;
    end
  end

  always_comb begin
    case (rs_q)
      RS_BASE: cfg_rdata = base_rd_q;
      RS_TIM:  cfg_rdata = tim_rd_q;
      default: cfg_rdata = '0;
    endcase
  end

  // R1: reset values of slots 0 and 1
  a_r1_reset_slot0: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (base_q[0] == {{(DATA_W-1){1'b0}}, ~swap_q}));
  a_r1_reset_slot1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (base_q[1] == '0));
  // R11: unmapped offsets read zero on the next cycle
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!is_base && !is_tim) |=> (cfg_rdata == '0));
  // R11: a write to an unmapped offset leaves the base words unchanged
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !is_base) |=> $stable(base_q));
endmodule

// File: rtl/csb_match.sv
`timescale 1ns/1ps
module csb_match #(
  parameter int NUM_BANKS = 8
) (
  input  logic [csb_pkg::ADDR_W-1:0]                addr,
  input  logic [NUM_BANKS-1:0][csb_pkg::DATA_W-1:0] bases,
  output logic [NUM_BANKS-1:0]                      hit,
  output logic [NUM_BANKS-1:0][csb_pkg::ADDR_W-1:0] offs
);
  import csb_pkg::*;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
    logic [CMP_W-1:0] mask, diff;
    logic             nominal;

    assign mask    = bases[g][CMP_W:1];
    assign diff    = (addr[ADDR_W-1:GRAN_LSB] ^ bases[g][ADDR_W-1:GRAN_LSB]) & mask;
    assign nominal = bases[g][0] && (diff == '0);
    assign offs[g] = addr & ~{mask, {GRAN_LSB{1'b0}}};

    if (g < 2) begin : g_legacy
      // Legacy slots: an all-zero word catches every address.
      assign hit[g] = nominal || (bases[g] == '0);
    end else begin : g_plain
      assign hit[g] = nominal;
    end
  end
endmodule

// File: rtl/csb_select.sv
`timescale 1ns/1ps
module csb_select #(
  parameter int NUM_BANKS = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      valid_i,
  input  logic                                      swap_i,
  input  logic [NUM_BANKS-1:0]                      hit,
  input  logic [NUM_BANKS-1:0][csb_pkg::ADDR_W-1:0] offs,
  output logic                                      out_valid,
  output logic [NUM_BANKS-1:0]                      cs_o,
  output logic [csb_pkg::ADDR_W-1:0]                off_o,
  output logic                                      err_o
);
  import csb_pkg::*;
  localparam int BW = $clog2(NUM_BANKS);

  logic [BW-1:0] win, pin;
  logic          any;

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win = BW'(i);
        any = 1'b1;
      end
    end
    pin = win;
    if (swap_i && (win < BW'(2))) pin = win ^ BW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cs_o      <= '0;
      off_o     <= '0;
      err_o     <= 1'b0;
    end else begin
      out_valid <= valid_i;
      cs_o      <= (valid_i && any) ? (NUM_BANKS'(1) << pin) : '0;
      off_o     <= (valid_i && any) ? offs[win] : '0;
      err_o     <= valid_i && !any;
    end
  end

  // R9: with the strap set, a slot-0 hit lands on line 1
  a_r9_swap_line: assert property (@(posedge clk) disable iff (rst)
    (valid_i && swap_i && hit[0]) |=> cs_o[1]);
  // R4: lowest slot wins when slot 0 hits without swap
  a_r4_slot0_first: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !swap_i && hit[0]) |=> (cs_o == NUM_BANKS'(1)));
endmodule

// File: rtl/csb_decoder.sv
`timescale 1ns/1ps
module csb_decoder #(
  parameter int NUM_BANKS = 8,
  parameter int TIM_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        boot_swap,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cpu_valid,
  input  logic [31:0] cpu_addr,
  output logic        out_valid,
  output logic [7:0]  cs,
  output logic [31:0] bank_off,
  output logic        dec_err
);
  import csb_pkg::*;

  logic [NUM_BANKS-1:0][DATA_W-1:0] bases;
  logic [NUM_BANKS-1:0]             hit;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] offs;
  logic                             swap;
  logic [NUM_BANKS-1:0]             cs_w;

  csb_regfile #(.NUM_BANKS(NUM_BANKS), .TIM_WORDS(TIM_WORDS)) u_regs (
    .clk(clk), .rst(rst), .boot_swap(boot_swap),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bases(bases), .swap_o(swap)
  );

  csb_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .addr(cpu_addr), .bases(bases), .hit(hit), .offs(offs)
  );

  csb_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .clk(clk), .rst(rst), .valid_i(cpu_valid), .swap_i(swap),
    .hit(hit), .offs(offs), .out_valid(out_valid), .cs_o(cs_w),
    .off_o(bank_off), .err_o(dec_err)
  );

  assign cs = cs_w;

  // R4: never more than one chip select
  a_r4_onehot_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));
  // R2: result follows a valid address by one cycle
  a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> out_valid);
  // R2: idle cycles show nothing
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |=> (!out_valid && cs == '0 && !dec_err));
  // R6: a miss carries no chip select and a zero offset
  a_r6_miss_clean: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (cs == '0 && bank_off == '0 && out_valid));
endmodule

// File: tb/tb_csb_decoder.sv
`timescale 1ns/1ps
module tb_csb_decoder;
  logic clk = 1'b0, rst = 1'b1, boot_swap = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0, bank_off;
  logic out_valid, dec_err;
  logic [7:0] cs;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] sh [8];
  bit sw;

  always #2 clk = ~clk;

  csb_decoder dut (
    .clk(clk), .rst(rst), .boot_swap(boot_swap), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .out_valid(out_valid),
    .cs(cs), .bank_off(bank_off), .dec_err(dec_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, output logic [7:0] ecs,
                                output logic [31:0] eoff, output logic eerr);
    ecs = '0; eoff = '0; eerr = 1'b1;
    for (int s = 7; s >= 0; s--) begin
      logic [14:0] m;
      logic h;
      m = sh[s][15:1];
      h = sh[s][0] && (((a[31:17] ^ sh[s][31:17]) & m) == '0);
      if (s < 2 && sh[s] == '0) h = 1'b1;
      if (h) begin
        int p;
        p = (sw && s < 2) ? (s ^ 1) : s;
        ecs = 8'(1) << p;
        eoff = a & ~{m, 17'b0};
        eerr = 1'b0;
      end
    end
  endfunction

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst = 1'b1; boot_swap = strap; cpu_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sw = strap;
    for (int i = 0; i < 8; i++) sh[i] = '0;
    sh[0] = {31'b0, ~strap};
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[11:8] == 4'h1 && a[7:4] < 8 && a[3:0] == 0) sh[a[6:4]] = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(posedge clk);
    #1 d = cfg_rdata;
  endtask

  task automatic dec(input string tag, input logic [31:0] a);
    logic [7:0] ecs; logic [31:0] eoff; logic eerr;
    model(a, ecs, eoff, eerr);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a;
    @(posedge clk);
    #1;
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " cs"}, {24'b0, cs}, {24'b0, ecs});
    chk({tag, " off"}, bank_off, eoff);
    chk({tag, " err"}, {31'b0, dec_err}, {31'b0, eerr});
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    do_reset(1'b0);
    // R1 reset values
    rd(12'h100, d); chk("R1 slot0 reset", d, 32'h1);
    rd(12'h110, d); chk("R1 slot1 reset", d, 32'h0);
    rd(12'h170, d); chk("R1 slot7 reset", d, 32'h0);
    // R2 idle: nothing valid after reset
    @(posedge clk); #1;
    chk("R2 idle valid", {31'b0, out_valid}, 0);
    chk("R2 idle cs", {24'b0, cs}, 0);
    dec("R7 enabled zero-mask slot0", 32'h1234_5678);
    // park slots 0 and 1 (R7), set real windows (R3, R5)
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h120, 32'h4200_FE01);
    wr(12'h150, 32'h4600_FF01);
    dec("R2 R5 slot2 window", 32'h43F0_0000);
    dec("R5 slot5 window", 32'h4620_0000);
    dec("R6 miss", 32'h5000_0000);
    dec("R7 parked slot0 top", 32'hFFFE_1234);
    // R3 mask: only bits 31:30 compared
    wr(12'h160, 32'h6000_C001);
    dec("R3 dont-care bits", 32'h6ABC_DEF0);
    dec("R3 compared bit miss", 32'hA000_0000);
    // R4 priority
    wr(12'h130, 32'h4200_FE01);
    dec("R4 lowest wins", 32'h4200_0040);
    // R8 zero word in slot 3 is disabled
    wr(12'h130, 32'h0);
    dec("R8 zero slot3 disabled", 32'h7000_0000);
    wr(12'h130, 32'h7000_F000);
    dec("R8 enable clear", 32'h7000_0000);
    // R7 zero slot1 catches all
    wr(12'h110, 32'h0);
    dec("R7 zero slot1 catch-all", 32'h7000_0000);
    wr(12'h110, 32'h5000_0000);
    dec("R7 nonzero disabled slot1", 32'h5000_0000);
    // R10 timing words
    wr(12'h238, 32'hA5A5_0001);
    wr(12'h370, 32'h0BAD_F00D);
    wr(12'h200, 32'h1111_2222);
    rd(12'h238, d); chk("R10 timing 0x238", d, 32'hA5A5_0001);
    rd(12'h370, d); chk("R10 timing 0x370", d, 32'h0BAD_F00D);
    rd(12'h200, d); chk("R10 timing 0x200", d, 32'h1111_2222);
    dec("R10 no decode effect", 32'h4620_0000);
    // R11 unmapped
    wr(12'h104, 32'hDEAD_BEEF);
    wr(12'h180, 32'hDEAD_BEEF);
    rd(12'h104, d); chk("R11 unmapped 0x104", d, 32'h0);
    rd(12'h180, d); chk("R11 unmapped 0x180", d, 32'h0);
    rd(12'h120, d); chk("R11 slot2 untouched", d, 32'h4200_FE01);
    rd(12'h100, d); chk("R11 slot0 untouched", d, 32'hFFFF_FFFF);
    // R9 swap
    do_reset(1'b1);
    rd(12'h100, d); chk("R1 slot0 reset swapped", d, 32'h0);
    dec("R9 swapped catch-all", 32'h1000_0000);
    wr(12'h100, 32'h4200_FE01);
    wr(12'h110, 32'h4200_FE01);
    dec("R9 slot0 on line1", 32'h4200_0000);
    dec("R9 miss", 32'h1000_0000);
    wr(12'h100, 32'hFFFF_FFFF);
    dec("R9 slot1 on line0", 32'h4200_0000);
    // random windows, both strap settings
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass[0]);
      for (int cfg = 0; cfg < 10; cfg++) begin
        for (int s = 0; s < 8; s++) begin
          logic [31:0] v;
          v = $urandom;
          v[15:1] = v[15:1] & 15'($urandom) & 15'($urandom);
          v[0] = ($urandom % 8) != 0;
          wr(12'h100 + 12'(s * 16), v);
        end
        for (int k = 0; k < 30; k++) begin
          logic [31:0] a;
          int s;
          s = $urandom % 8;
          a = {sh[s][31:17], 17'($urandom)};
          if ($urandom % 2) a = a ^ ($urandom & $urandom & $urandom & 32'hFFFE_0000);
          if ($urandom % 4 == 0) a = $urandom;
          dec("R3 R4 R5 R6 random", a);
        end
      end
    end
    finish_run();
  end
endmodule